// File: doc/BRIEF.md
# Standby Wakeup Control and Status Register

This block is one 32-bit control/status word of a power-management unit, reached over an APB slave port. Software uses it to choose which of two external wakeup pins may bring the device out of standby, and to find out afterwards what happened. It shows whether the device has been in standby, whether a wakeup pin event has occurred, and a gated view of the supply-voltage comparator.

Each wakeup pin passes through a two-flop synchronizer and a rising-edge detector. An edge on an enabled pin produces a one-cycle wakeup request toward the power sequencer. The standby flag has its own set strobe, which marks standby entry, and its own clear strobe from the control register. The register keeps two reset domains apart. Power-on reset clears everything. System reset clears everything except the standby flag. Standby entry and exit never touch the pin enables. Reads take one wait state and writes take none.

Top module: `stby_wake_csr`

## Requirements
- R1: After power-on reset every bit of the register reads 0, `pready` is 1 while idle and `wake_req` is 0.
- R2: The register answers at offset 0x4. Bit 8 enables wakeup pin 0 and bit 9 enables wakeup pin 1, and both are read/write. Bit 0 is the wakeup flag, bit 1 the standby flag and bit 2 the comparator view, and all three are read-only. All other bits read 0 and ignore writes. Any other offset reads 0 and ignores writes.
- R3: A read access holds `pready` low for exactly one cycle. A write access completes with `pready` high in its first access cycle.
- R4: A rising edge on `wake_pin[i]` while enable bit i is 1 gives a `wake_req` pulse exactly one cycle wide. The pulse appears after the third rising clock edge following the pin change. A pin that stays high, a falling edge, or an edge on a disabled pin gives no pulse. Simultaneous edges on both pins give a single one-cycle pulse.
- R5: The wakeup flag (bit 0) becomes 1 in the cycle after a wakeup request. Only system reset or power-on reset clears it.
- R6: The standby flag (bit 1) becomes 1 after a `stby_enter` pulse and 0 after a `stby_clr` pulse. When both pulses arrive in the same cycle, the flag is set. Power-on reset clears the flag, and system reset leaves it unchanged.
- R7: System reset clears both pin enables and the wakeup flag.
- R8: Bit 2 shows the synchronized `pvd_cmp` value while `pvd_en` is 1 and the comparator view is armed. Bit 2 reads 0 whenever `pvd_en` is 0.
- R9: After any reset, and after a `stby_enter` pulse, bit 2 reads 0 until a 0-to-1 change of `pvd_en` has been sampled. A `pvd_en` that is already 1 when reset is released counts as such a change.
- R10: Standby entry and wakeup requests leave the pin enables unchanged. Only a write to the register changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| por_n | input | 1 | Power-on reset, active low, clears every flop |
| sys_rst_n | input | 1 | System reset, active low, spares the standby flag |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, low for the read wait state |
| wake_pin | input | N_PIN | Asynchronous wakeup pins |
| pvd_en | input | 1 | Voltage comparator enable |
| pvd_cmp | input | 1 | Voltage comparator output, 1 = supply above threshold |
| stby_enter | input | 1 | One-cycle strobe marking standby entry |
| stby_clr | input | 1 | One-cycle strobe clearing the standby flag |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
The standby flag's set strobe and clear strobe can fall in the same clock cycle. The bench drives `stby_enter` and `stby_clr` high together for one edge. It then reads the register and expects bit 1 to be 1, since the set must win. A second collision comes from the two wakeup pins: both pins rise at the same instant while both are enabled. The bench counts the high cycles of `wake_req` and expects exactly one.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    // Read-only status field positions; software decodes these
    localparam int WUF_POS = 0;
    localparam int SBF_POS = 1;
    localparam int PVD_POS = 2;
    localparam int STAT_W  = 3;

    // Flags kept in the system-reset domain
    typedef struct packed {
        logic wuf;
        logic arm;
        logic pvd_prev;
    } sys_flags_t;

    // Flags kept only in the power-on domain
    typedef struct packed {
        logic sbf;
    } por_flags_t;

endpackage

// File: rtl/sbw_sync.sv
module sbw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
        dout    = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

endmodule

// File: rtl/sbw_wake.sv
module sbw_wake #(
    parameter int N_PIN       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin,
    input  logic [N_PIN-1:0] en,
    output logic             wake_req
);

    typedef struct packed {
        logic [N_PIN-1:0] prev;
        logic             pulse;
    } wake_st_t;

    wake_st_t         st_d, st_q;
    logic [N_PIN-1:0] pin_s;
    logic [N_PIN-1:0] rise;

    sbw_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin),
        .dout (pin_s)
    );

    always_comb begin
        rise       = pin_s & ~st_q.prev;
        st_d.prev  = pin_s;
        st_d.pulse = |(rise & en);
        wake_req   = st_q.pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a request only follows a cycle where some pin was enabled
    assert_wake_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(en != '0));

endmodule

// File: rtl/sbw_status.sv
module sbw_status
    import sbw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_sys_n,
    input  logic              stby_enter,
    input  logic              stby_clr,
    input  logic              wake_req,
    input  logic              pvd_en,
    input  logic              pvd_cmp,
    output logic [STAT_W-1:0] stat_bits
);

    por_flags_t por_d, por_q;
    sys_flags_t sys_d, sys_q;
    logic       cmp_s;

    sbw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_cmp_sync (
        .clk  (clk),
        .rst_n(rst_sys_n),
        .din  (pvd_cmp),
        .dout (cmp_s)
    );

    always_comb begin
        // set has priority over clear
        por_d.sbf      = stby_enter | (por_q.sbf & ~stby_clr);

        sys_d.pvd_prev = pvd_en;
        sys_d.wuf      = sys_q.wuf | wake_req;
        if (stby_enter) sys_d.arm = 1'b0;
        else            sys_d.arm = sys_q.arm | (pvd_en & ~sys_q.pvd_prev);

        stat_bits          = '0;
        stat_bits[WUF_POS] = sys_q.wuf;
        stat_bits[SBF_POS] = por_q.sbf;
        stat_bits[PVD_POS] = sys_q.arm & pvd_en & cmp_s;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) por_q <= '0;
        else        por_q <= por_d;
    end

    always_ff @(posedge clk or negedge rst_sys_n) begin
        if (!rst_sys_n) sys_q <= '0;
        else            sys_q <= sys_d;
    end

    assert_sbf_set_R6: assert property (@(posedge clk) disable iff (!por_n)
        stby_enter |=> stat_bits[SBF_POS]);

    assert_sbf_keep_R6: assert property (@(posedge clk) disable iff (!por_n)
        (stat_bits[SBF_POS] && !stby_clr) |=> stat_bits[SBF_POS]);

    assert_sbf_clr_R6: assert property (@(posedge clk) disable iff (!por_n)
        (stby_clr && !stby_enter) |=> !stat_bits[SBF_POS]);

    assert_wuf_set_R5: assert property (@(posedge clk) disable iff (!rst_sys_n)
        wake_req |=> stat_bits[WUF_POS]);

    assert_pvd_blank_R9: assert property (@(posedge clk) disable iff (!rst_sys_n)
        stby_enter |=> !stat_bits[PVD_POS]);

endmodule

// File: rtl/sbw_apb.sv
module sbw_apb
    import sbw_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int N_PIN   = 2,
    parameter int REG_OFS = 4,
    parameter int EN_LSB  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [STAT_W-1:0] stat_bits,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic [N_PIN-1:0]  pin_en
);

    typedef struct packed {
        logic [N_PIN-1:0] en;
        logic             rd_wait;
    } apb_st_t;

    apb_st_t st_d, st_q;
    logic    hit, rd_acc, wr_acc;
    logic    unused_wdata;

    assign unused_wdata = ^pwdata;

    always_comb begin
        hit    = (paddr == ADDR_W'(REG_OFS));
        rd_acc = psel & penable & ~pwrite;
        wr_acc = psel & penable & pwrite;

        st_d         = st_q;
        st_d.rd_wait = rd_acc & ~st_q.rd_wait;
        if (wr_acc && hit) st_d.en = pwdata[EN_LSB +: N_PIN];

        prdata = '0;
        if (rd_acc && hit) begin
            prdata[STAT_W-1:0]        = stat_bits;
            prdata[EN_LSB +: N_PIN]   = st_q.en;
        end
        pready = ~rd_acc | st_q.rd_wait;
        pin_en = st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: first cycle of a read access is always a wait state
    assert_rd_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && !$past(psel && penable)) |-> !pready);

    // R3: writes never stall
    assert_wr_nowait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite) |-> pready);

    // R10: enables move only on a write access
    assert_en_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(pin_en));

endmodule

// File: rtl/stby_wake_csr.sv
module stby_wake_csr
    import sbw_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int N_PIN       = 2,
    parameter int REG_OFS     = 4,
    parameter int EN_LSB      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic [N_PIN-1:0]  wake_pin,
    input  logic              pvd_en,
    input  logic              pvd_cmp,
    input  logic              stby_enter,
    input  logic              stby_clr,
    output logic              wake_req
);

    logic              rst_sys_n;
    logic [N_PIN-1:0]  pin_en;
    logic [STAT_W-1:0] stat_bits;

    assign rst_sys_n = por_n & sys_rst_n;

    sbw_apb #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_PIN  (N_PIN),
        .REG_OFS(REG_OFS),
        .EN_LSB (EN_LSB)
    ) u_apb (
        .clk      (clk),
        .rst_n    (rst_sys_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .stat_bits(stat_bits),
        .prdata   (prdata),
        .pready   (pready),
        .pin_en   (pin_en)
    );

    sbw_wake #(
        .N_PIN      (N_PIN),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_sys_n),
        .pin     (wake_pin),
        .en      (pin_en),
        .wake_req(wake_req)
    );

    sbw_status #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_status (
        .clk       (clk),
        .por_n     (por_n),
        .rst_sys_n (rst_sys_n),
        .stby_enter(stby_enter),
        .stby_clr  (stby_clr),
        .wake_req  (wake_req),
        .pvd_en    (pvd_en),
        .pvd_cmp   (pvd_cmp),
        .stat_bits (stat_bits)
    );

endmodule

// File: tb/sim_stby_wake_csr.sv
module sim_stby_wake_csr;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] REG_A = 4'h4;

    logic        clk = 1'b0;
    logic        por_n, sys_rst_n;
    logic        psel, penable, pwrite;
    logic [3:0]  paddr;
    logic [31:0] pwdata, prdata;
    logic        pready;
    logic [1:0]  wake_pin;
    logic        pvd_en, pvd_cmp, stby_enter, stby_clr, wake_req;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stby_wake_csr u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .wake_pin(wake_pin), .pvd_en(pvd_en), .pvd_cmp(pvd_cmp),
        .stby_enter(stby_enter), .stby_clr(stby_clr), .wake_req(wake_req)
    );

    typedef struct packed {
        logic [3:0]  waddr;
        logic [31:0] wdata;
        logic [31:0] expv;
    } vec_t;

    // R2 register map walk: write, then read back at 0x4
    localparam vec_t VECS [11] = '{
        '{4'h4, 32'h0000_0300, 32'h0000_0300},
        '{4'h4, 32'h0000_0100, 32'h0000_0100},
        '{4'h4, 32'h0000_0200, 32'h0000_0200},
        '{4'h4, 32'hFFFF_FCFF, 32'h0000_0000},
        '{4'h4, 32'hFFFF_FFFF, 32'h0000_0300},
        '{4'h4, 32'h0000_0007, 32'h0000_0000},
        '{4'h0, 32'h0000_0300, 32'h0000_0000},
        '{4'h8, 32'h0000_0100, 32'h0000_0000},
        '{4'h4, 32'h0000_0100, 32'h0000_0100},
        '{4'hC, 32'h0000_0000, 32'h0000_0100},
        '{4'h4, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] expv);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", what, got, expv);
        end
    endtask

    task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk("R3 write ready in first access cycle", {31'd0, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [3:0] a, output logic [31:0] d);
        int waits;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        waits = 0;
        while (!pready && waits < 8) begin
            waits++;
            @(negedge clk);
            #1;
        end
        d = prdata;
        chk("R3 read wait states", 32'(waits), 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string what, input logic [31:0] expv);
        logic [31:0] v;
        apb_rd(REG_A, v);
        chk(what, v, expv);
    endtask

    // Drive pins at a falling edge, then watch wake_req for n cycles
    task automatic pins_watch(input logic [1:0] p, input int n, output int cnt, output int first);
        @(negedge clk);
        wake_pin = p;
        cnt = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            #1;
            if (wake_req) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic pulse_stby(input logic s, input logic c);
        @(negedge clk);
        stby_enter = s; stby_clr = c;
        @(negedge clk);
        stby_enter = 1'b0; stby_clr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired got=hang exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt, first;
        logic [31:0] v;
        por_n = 1'b0; sys_rst_n = 1'b0;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
        wake_pin = 2'b00; pvd_en = 1'b0; pvd_cmp = 1'b0;
        stby_enter = 1'b0; stby_clr = 1'b0;
        wait_cyc(3);
        por_n = 1'b1; sys_rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        chk("R1 idle pready", {31'd0, pready}, 32'd1);
        chk("R1 wake_req low", {31'd0, wake_req}, 32'd0);
        rd_chk("R1 register after power-on", 32'h0);

        // R2 table walk
        foreach (VECS[i]) begin
            apb_wr(VECS[i].waddr, VECS[i].wdata);
            rd_chk($sformatf("R2 vector %0d", i), VECS[i].expv);
        end

        // R2 other offsets read zero
        apb_wr(REG_A, 32'h300);
        apb_rd(4'h0, v);
        chk("R2 offset 0 reads zero", v, 32'h0);
        apb_rd(4'h8, v);
        chk("R2 offset 8 reads zero", v, 32'h0);
        apb_wr(REG_A, 32'h100);

        // R4 wake pulse latency and width
        pins_watch(2'b01, 8, cnt, first);
        chk("R4 pin0 pulse count", 32'(cnt), 32'd1);
        chk("R4 pin0 pulse latency", 32'(first), 32'd3);
        pins_watch(2'b01, 8, cnt, first);
        chk("R4 held pin no pulse", 32'(cnt), 32'd0);
        pins_watch(2'b11, 8, cnt, first);
        chk("R4 disabled pin1 no pulse", 32'(cnt), 32'd0);

        // R5 wakeup flag
        rd_chk("R5 wakeup flag set", 32'h101);

        apb_wr(REG_A, 32'h300);
        pins_watch(2'b11, 8, cnt, first);
        chk("R4 enabling a high pin no pulse", 32'(cnt), 32'd0);
        pins_watch(2'b00, 6, cnt, first);
        chk("R4 falling edges no pulse", 32'(cnt), 32'd0);
        pins_watch(2'b11, 8, cnt, first);
        chk("R4 simultaneous edges one pulse", 32'(cnt), 32'd1);
        rd_chk("R5 flag after second wake", 32'h301);

        // R6/R10 standby entry keeps enables
        pulse_stby(1'b1, 1'b0);
        rd_chk("R6 R10 standby flag set enables kept", 32'h303);

        // R7 system reset
        @(negedge clk); sys_rst_n = 1'b0;
        wait_cyc(2);
        sys_rst_n = 1'b1;
        pins_watch(2'b11, 8, cnt, first);
        chk("R7 no wake after reset clears enables", 32'(cnt), 32'd0);
        rd_chk("R7 R6 sys reset clears enables and wuf, keeps sbf", 32'h002);

        // R6 clear and collision
        pulse_stby(1'b0, 1'b1);
        rd_chk("R6 standby flag cleared", 32'h0);
        pulse_stby(1'b1, 1'b1);
        rd_chk("R6 set wins over clear", 32'h002);

        // R1 power-on reset clears standby flag
        wake_pin = 2'b00;
        @(negedge clk); por_n = 1'b0;
        wait_cyc(2);
        por_n = 1'b1;
        wait_cyc(1);
        rd_chk("R1 R6 power-on clears all", 32'h0);

        // R8/R9 comparator view
        pvd_cmp = 1'b1;
        wait_cyc(4);
        rd_chk("R8 disabled comparator reads zero", 32'h0);
        pvd_en = 1'b1;
        wait_cyc(4);
        rd_chk("R8 comparator high", 32'h004);
        pvd_cmp = 1'b0;
        wait_cyc(4);
        rd_chk("R8 comparator low", 32'h0);
        pvd_cmp = 1'b1;
        wait_cyc(4);
        rd_chk("R8 comparator high again", 32'h004);
        pulse_stby(1'b1, 1'b0);
        wait_cyc(2);
        rd_chk("R9 blanked after standby", 32'h002);
        pvd_en = 1'b0;
        wait_cyc(2);
        pvd_en = 1'b1;
        wait_cyc(4);
        rd_chk("R9 re-armed by enable toggle", 32'h006);
        pvd_en = 1'b0;
        wait_cyc(2);
        rd_chk("R8 enable low forces zero", 32'h002);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule